// File: doc/BRIEF.md
# SPI EEPROM Boot Reader

This block is an SPI master that fetches a boot image from a serial EEPROM after a start pulse. It lowers chip select, sends a read command for address zero, and then clocks in the image one byte at a time. The first bytes form a header. The header holds an 8-bit stream key, a peripheral clock prescaler setting, a new SCK divider, reserved filler and a 32-bit entry point whose bytes arrive in a scrambled order. The reader checks the key and applies the two clock settings. It drops the filler and rebuilds the entry point. Every byte after the header goes out as a one-cycle pulse for a downstream block decoder.

The reader starts at its slowest SCK rate, because nothing is yet known about the part on the other end. It speeds itself up in the middle of the stream when the image asks for a faster divider. A new divider never cuts into a byte that is already moving. It takes effect on the next whole byte. Only 8-bit images are accepted. A wrong key stops the transfer, releases chip select and raises a fail flag, so the system can boot from somewhere else.

Top module: `spi_boot_reader`

## Requirements
- R1: After reset, chip select is high and SCK and MOSI are low. No byte pulse, entry-valid or key-fail output is high, and the prescaler output shows its default value 2.
- R2: A start pulse drives chip select low and shifts out the bytes 0x03, 0x00, 0x00 MSB first in SPI mode 0. SCK idles low, MOSI is steady while SCK is high, and MISO is sampled on the rising edge. SCK never runs while chip select is high.
- R3: Until the image changes it, the divider is 0x7F, which gives an SCK period of (0x7F+1)*4 = 512 system clocks.
- R4: Image byte 1 must be 0xAA and byte 2 must be 0x08, since only the 8-bit format is accepted. Any other value, including the 16-bit key pair 0xAA, 0x10, sets key-fail and raises chip select. Nothing is forwarded and entry-valid stays low.
- R5: Image byte 3 is the prescaler value. When it differs from the current value it replaces the prescaler output.
- R6: Image byte 4 is the SCK divider. When it differs from 0x7F it is adopted and the SCK period becomes (divider+1)*4 clocks, starting with the next byte. A value of 0x7F leaves the period at 512. The period never changes inside a byte.
- R7: Image bytes 5 to 18, seven 16-bit filler words, are read and discarded. No byte pulse is produced for them.
- R8: Image bytes 19, 20, 21 and 22 give entry-point bits [23:16], [31:24], [7:0] and [15:8] in that order. After byte 22 entry-valid goes high, and the address stays stable while entry-valid is high.
- R9: Every image byte from byte 23 on is presented on the data output with a byte-valid pulse that lasts one clock. The bytes keep their order and none is skipped.
- R10: A stop request during forwarding lets the byte in flight finish and be forwarded. No further byte is read, and chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a boot read |
| stop_i | input | 1 | Pulse from the downstream decoder that ends forwarding |
| spi_miso_i | input | 1 | Serial data from the EEPROM |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the EEPROM |
| spi_cs_n_o | output | 1 | EEPROM chip select, active low |
| presc_o | output | 8 | Peripheral clock prescaler setting taken from the image |
| entry_valid_o | output | 1 | Entry point has been assembled |
| entry_addr_o | output | 32 | Assembled entry point |
| key_fail_o | output | 1 | Stream key rejected, so use the fallback boot path |
| byte_valid_o | output | 1 | One-cycle strobe for a forwarded image byte |
| byte_data_o | output | 8 | Forwarded image byte |

## Verification
The assertions check the SPI line rules on every cycle. SCK must stay low whenever chip select is high, MOSI must hold while SCK is high, and each SCK high phase must last at least two clocks. They also check that the byte strobe is a single pulse, that a key failure never comes with forwarding or an entry point, and that the entry address stays put while it is flagged valid. The bench scenarios cover the rest. These are the command bytes sent out, the 512-clock start-up period, and the faster period measured after a new divider. They also cover prescaler capture, the scrambled entry-point order, the dropped filler, the exact forwarded byte sequence, the one-byte overrun after a stop request, and the two ways the key can be rejected.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_HDR,
    ST_STREAM,
    ST_FAIL
  } seq_st_t;

  localparam logic [7:0] RD_OPCODE  = 8'h03;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h08;
  localparam int         IDX_W      = 5;
  localparam logic [IDX_W-1:0] CMD_LAST   = 5'd2;
  localparam logic [IDX_W-1:0] IDX_KEY0   = 5'd0;
  localparam logic [IDX_W-1:0] IDX_KEY1   = 5'd1;
  localparam logic [IDX_W-1:0] IDX_PRESC  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_DIV    = 5'd3;
  localparam logic [IDX_W-1:0] IDX_EP_B2  = 5'd18;
  localparam logic [IDX_W-1:0] IDX_EP_B3  = 5'd19;
  localparam logic [IDX_W-1:0] IDX_EP_B0  = 5'd20;
  localparam logic [IDX_W-1:0] IDX_EP_B1  = 5'd21;
endpackage

// File: rtl/spi_boot_tick.sv
module spi_boot_tick #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == limit);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_boot_byte.sv
module spi_boot_byte #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       tx,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [7:0]       rx,
  output logic             done,
  output logic             busy
);
  localparam int HALF_W = DIV_W + 1;

  logic             busy_q, busy_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic [3:0]       ph_q, ph_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic             tick;

  spi_boot_tick #(.CW(HALF_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .limit ({div_q, 1'b1}),
    .tick  (tick)
  );

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    ph_d   = ph_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        div_d  = div;
        sh_d   = tx;
        ph_d   = '0;
        sck_d  = 1'b0;
      end
    end else if (tick) begin
      ph_d = ph_q + 1'b1;
      if (!ph_q[0]) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        sh_d  = {sh_q[6:0], 1'b0};
        if (ph_q == 4'd15) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      ph_q   <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      ph_q   <= ph_d;
      sck_q  <= sck_d;
      done_q <= done_d;
    end
  end

  assign sck  = sck_q;
  assign mosi = busy_q & sh_q[7];
  assign rx   = rx_q;
  assign done = done_q;
  assign busy = busy_q;
endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
  import spi_boot_pkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [DIV_W-1:0] SLOW_DIV  = 8'h7F,
  parameter logic [7:0]     PRESC_DEF = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             done,
  input  logic             busy,
  input  logic [7:0]       rx,
  output logic             go,
  output logic [7:0]       tx,
  output logic [DIV_W-1:0] div,
  output logic             cs_n,
  output logic [7:0]       presc,
  output logic [31:0]      entry_addr,
  output logic             entry_valid,
  output logic             key_fail,
  output logic             byte_valid,
  output logic [7:0]       byte_data
);
  seq_st_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       presc_q, presc_d;
  logic [31:0]      ep_q, ep_d;
  logic             epv_q, epv_d;
  logic             fail_q, fail_d;
  logic             bv_q, bv_d;
  logic [7:0]       bd_q, bd_d;
  logic             stop_q, stop_d;
  logic             cs_n_q, cs_n_d;
  logic             active;

  assign active = (st_q == ST_CMD) || (st_q == ST_HDR) || (st_q == ST_STREAM);
  assign go     = active && !busy && !done && !((st_q == ST_STREAM) && stop_q);
  assign tx     = ((st_q == ST_CMD) && (idx_q == '0)) ? RD_OPCODE : 8'h00;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    div_d   = div_q;
    presc_d = presc_q;
    ep_d    = ep_q;
    epv_d   = epv_q;
    fail_d  = fail_q;
    bv_d    = 1'b0;
    bd_d    = bd_q;
    stop_d  = stop_q | stop_i;
    case (st_q)
      ST_IDLE, ST_FAIL: begin
        if (start_i) begin
          st_d    = ST_CMD;
          idx_d   = '0;
          div_d   = SLOW_DIV;
          presc_d = PRESC_DEF;
          ep_d    = '0;
          epv_d   = 1'b0;
          fail_d  = 1'b0;
          stop_d  = 1'b0;
        end
      end
      ST_CMD: begin
        if (done) begin
          if (idx_q == CMD_LAST) begin
            st_d  = ST_HDR;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_HDR: begin
        if (done) begin
          idx_d = idx_q + 1'b1;
          case (idx_q)
            IDX_KEY0: if (rx != KEY_FIRST) begin
              st_d   = ST_FAIL;
              fail_d = 1'b1;
            end
            IDX_KEY1: if (rx != KEY_SECOND) begin
              st_d   = ST_FAIL;
              fail_d = 1'b1;
            end
            IDX_PRESC: if (rx != presc_q) presc_d = rx;
            IDX_DIV:   if (rx != SLOW_DIV) div_d = rx;
            IDX_EP_B2: ep_d[23:16] = rx;
            IDX_EP_B3: ep_d[31:24] = rx;
            IDX_EP_B0: ep_d[7:0]   = rx;
            IDX_EP_B1: begin
              ep_d[15:8] = rx;
              epv_d      = 1'b1;
              st_d       = ST_STREAM;
            end
            default: ;
          endcase
        end
      end
      ST_STREAM: begin
        if (done) begin
          bv_d = 1'b1;
          bd_d = rx;
        end else if (stop_q && !busy) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cs_n_d = !((st_d == ST_CMD) || (st_d == ST_HDR) || (st_d == ST_STREAM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      div_q   <= SLOW_DIV;
      presc_q <= PRESC_DEF;
      ep_q    <= '0;
      epv_q   <= 1'b0;
      fail_q  <= 1'b0;
      bv_q    <= 1'b0;
      bd_q    <= '0;
      stop_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      div_q   <= div_d;
      presc_q <= presc_d;
      ep_q    <= ep_d;
      epv_q   <= epv_d;
      fail_q  <= fail_d;
      bv_q    <= bv_d;
      bd_q    <= bd_d;
      stop_q  <= stop_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign div         = div_q;
  assign cs_n        = cs_n_q;
  assign presc       = presc_q;
  assign entry_addr  = ep_q;
  assign entry_valid = epv_q;
  assign key_fail    = fail_q;
  assign byte_valid  = bv_q;
  assign byte_data   = bd_q;
endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader #(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] SLOW_DIV  = 8'h7F,
  parameter logic [7:0]       PRESC_DEF = 8'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        spi_miso_i,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  output logic        spi_cs_n_o,
  output logic [7:0]  presc_o,
  output logic        entry_valid_o,
  output logic [31:0] entry_addr_o,
  output logic        key_fail_o,
  output logic        byte_valid_o,
  output logic [7:0]  byte_data_o
);
  logic             go, done, busy;
  logic [7:0]       tx, rx;
  logic [DIV_W-1:0] div;

  spi_boot_byte #(.DIV_W(DIV_W)) u_byte (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .tx    (tx),
    .div   (div),
    .miso  (spi_miso_i),
    .sck   (spi_sck_o),
    .mosi  (spi_mosi_o),
    .rx    (rx),
    .done  (done),
    .busy  (busy)
  );

  spi_boot_seq #(
    .DIV_W     (DIV_W),
    .SLOW_DIV  (SLOW_DIV),
    .PRESC_DEF (PRESC_DEF)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .done        (done),
    .busy        (busy),
    .rx          (rx),
    .go          (go),
    .tx          (tx),
    .div         (div),
    .cs_n        (spi_cs_n_o),
    .presc       (presc_o),
    .entry_addr  (entry_addr_o),
    .entry_valid (entry_valid_o),
    .key_fail    (key_fail_o),
    .byte_valid  (byte_valid_o),
    .byte_data   (byte_data_o)
  );
endmodule

// File: rtl/spi_boot_chk.sv
module spi_boot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n_o,
  input logic        spi_sck_o,
  input logic        spi_mosi_o,
  input logic        byte_valid_o,
  input logic        key_fail_o,
  input logic        entry_valid_o,
  input logic [31:0] entry_addr_o
);
  // R2
  sck_quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o);

  // R2
  mosi_steady_while_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

  // R6
  sck_high_min_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck_o) |=> spi_sck_o);

  // R9
  byte_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

  // R4
  fail_blocks_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail_o |-> (!byte_valid_o && !entry_valid_o && spi_cs_n_o));

  // R8
  entry_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && $past(entry_valid_o)) |-> $stable(entry_addr_o));
endmodule

bind spi_boot_reader spi_boot_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_cs_n_o    (spi_cs_n_o),
  .spi_sck_o     (spi_sck_o),
  .spi_mosi_o    (spi_mosi_o),
  .byte_valid_o  (byte_valid_o),
  .key_fail_o    (key_fail_o),
  .entry_valid_o (entry_valid_o),
  .entry_addr_o  (entry_addr_o)
);

// File: tb/tb_spi_boot_reader.sv
module tb_spi_boot_reader;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        stop_i;
  logic        miso;
  logic        spi_sck_o, spi_mosi_o, spi_cs_n_o;
  logic [7:0]  presc_o;
  logic        entry_valid_o;
  logic [31:0] entry_addr_o;
  logic        key_fail_o;
  logic        byte_valid_o;
  logic [7:0]  byte_data_o;

  spi_boot_reader dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .spi_miso_i    (miso),
    .spi_sck_o     (spi_sck_o),
    .spi_mosi_o    (spi_mosi_o),
    .spi_cs_n_o    (spi_cs_n_o),
    .presc_o       (presc_o),
    .entry_valid_o (entry_valid_o),
    .entry_addr_o  (entry_addr_o),
    .key_fail_o    (key_fail_o),
    .byte_valid_o  (byte_valid_o),
    .byte_data_o   (byte_data_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // EEPROM model: captures the command, then serves the image in mode 0
  logic [7:0]  img [0:63];
  int          bitcnt = 0;
  logic [23:0] cmd_word = '0;

  always @(posedge spi_sck_o or posedge spi_cs_n_o) begin
    if (spi_cs_n_o) bitcnt = 0;
    else begin
      if (bitcnt < 24) cmd_word = {cmd_word[22:0], spi_mosi_o};
      bitcnt = bitcnt + 1;
    end
  end

  always @(negedge spi_sck_o) begin
    if (!spi_cs_n_o && bitcnt >= 24 && ((bitcnt - 24) / 8) < 64)
      miso = img[(bitcnt - 24) / 8][7 - ((bitcnt - 24) % 8)];
  end

  // Output monitor
  logic [7:0] got [0:15];
  int   nb = 0;
  bit   early_valid = 0;
  int   nrise = 0;
  int   last_rise = 0;
  int   per_first = 0;
  int   per_last = 0;
  logic sck_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && byte_valid_o) begin
      if (nb < 16) got[nb] = byte_data_o;
      nb = nb + 1;
      if (!entry_valid_o) early_valid = 1;
    end
    if (spi_sck_o && !sck_prev) begin
      if (nrise >= 1) begin
        per_last = cyc - last_rise;
        if (nrise == 1) per_first = per_last;
      end
      last_rise = cyc;
      nrise = nrise + 1;
    end
    sck_prev = spi_sck_o;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0;
    early_valid = 0;
    nrise = 0;
    per_first = 0;
    per_last = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    start_i = 1'b0;
    stop_i  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    clear_mon();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_cs(input logic level);
    while (spi_cs_n_o !== level) @(negedge clk);
  endtask

  task automatic fill_header(input logic [7:0] k0, input logic [7:0] k1,
                             input logic [7:0] pr, input logic [7:0] dv);
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    img[0] = k0;
    img[1] = k1;
    img[2] = pr;
    img[3] = dv;
    for (int i = 4; i < 18; i++) img[i] = 8'h60 + 8'(i);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(spi_cs_n_o === 1'b1, "R1 cs_n", spi_cs_n_o, 1);
    check(spi_sck_o === 1'b0 && spi_mosi_o === 1'b0, "R1 sck/mosi", {spi_sck_o, spi_mosi_o}, 0);
    check(byte_valid_o === 1'b0 && entry_valid_o === 1'b0 && key_fail_o === 1'b0,
          "R1 flags", {byte_valid_o, entry_valid_o, key_fail_o}, 0);
    check(presc_o === 8'd2, "R1 presc default", presc_o, 2);
  endtask

  task automatic t_good_stream();
    fill_header(8'hAA, 8'h08, 8'h05, 8'h01);
    img[18] = 8'h34; img[19] = 8'h12; img[20] = 8'h78; img[21] = 8'h56;
    for (int i = 0; i < 8; i++) img[22 + i] = 8'hA1 + 8'(i);
    do_reset();
    pulse_start();
    while (nb < 6) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    wait_cs(1'b1);
    repeat (100) @(negedge clk);
    check(cmd_word === 24'h030000, "R2 read command", cmd_word, 24'h030000);
    check(per_first == 512, "R3 initial SCK period", per_first, 512);
    check(presc_o === 8'h05, "R5 prescaler", presc_o, 5);
    check(per_last == 8, "R6 SCK period after divider 1", per_last, 8);
    check(early_valid == 0, "R7 filler forwarded", early_valid, 0);
    check(entry_valid_o === 1'b1, "R8 entry valid", entry_valid_o, 1);
    check(entry_addr_o === 32'h12345678, "R8 entry order", entry_addr_o, 32'h12345678);
    check(nb == 7, "R10 bytes after stop", nb, 7);
    for (int k = 0; k < 7; k++)
      check(got[k] === 8'hA1 + 8'(k), "R9 forwarded byte", got[k], 8'hA1 + k);
    check(spi_cs_n_o === 1'b1 && key_fail_o === 1'b0, "R10 deselected", spi_cs_n_o, 1);
  endtask

  task automatic t_bad_first();
    fill_header(8'h55, 8'h08, 8'h02, 8'h01);
    do_reset();
    pulse_start();
    wait_cs(1'b0);
    wait_cs(1'b1);
    repeat (20) @(negedge clk);
    check(key_fail_o === 1'b1, "R4 bad first key byte", key_fail_o, 1);
    check(nb == 0 && entry_valid_o === 1'b0, "R4 nothing forwarded", nb, 0);
  endtask

  task automatic t_sixteen_bit_key();
    fill_header(8'hAA, 8'h10, 8'h02, 8'h01);
    do_reset();
    pulse_start();
    wait_cs(1'b0);
    wait_cs(1'b1);
    repeat (20) @(negedge clk);
    check(key_fail_o === 1'b1, "R4 16-bit key rejected", key_fail_o, 1);
    check(nb == 0 && entry_valid_o === 1'b0, "R4 no output on 16-bit key", nb, 0);
    check(spi_sck_o === 1'b0, "R4 SCK idle after fail", spi_sck_o, 0);
  endtask

  task automatic t_keep_slow();
    fill_header(8'hAA, 8'h08, 8'h02, 8'h7F);
    do_reset();
    pulse_start();
    while (bitcnt < 24 + 8*4 + 5) @(negedge clk);
    @(negedge clk);
    check(per_last == 512, "R6 divider 0x7F keeps 512", per_last, 512);
    check(presc_o === 8'h02, "R5 same prescaler", presc_o, 2);
    check(key_fail_o === 1'b0 && nb == 0, "R7 no forwarding in header", nb, 0);
    t_reset_state();
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    stop_i  = 1'b0;
    miso    = 1'b0;
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    t_reset_state();
    t_good_stream();
    t_bad_first();
    t_sixteen_bit_key();
    t_keep_slow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule